// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked user port and an external asynchronous static RAM of 128K words by 16 bits. The RAM has active-low chip enable, output enable and write enable pins, plus one active-low strobe for each byte lane. A user asserts `req` with a direction flag, a word address, write data and a byte mask. The controller takes the request when `ready` is high. It then produces the pin sequence for one access and reports the result. A read returns its data with a single-cycle `rd_valid`. A write ends with a single-cycle `done`.

Every timing limit of the memory is a parameter in nanoseconds, alongside the clock period. Each phase lasts the rounded-up number of clock cycles, and never less than one. The shared data bus is split into an output value, a drive-enable and an input value, so the pad cell stays outside the block. Bus turnaround is ordered so that the controller and the RAM never drive the bus together. A write whose mask is all zeros never touches the array.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset, all five memory control pins are high, `mem_dq_oe` is low, `ready` is high, and `rd_valid` and `done` are low.
- R2: `ready` is high only while the controller is idle. A request is taken on a clock edge where `req` and `ready` are both high, and `ready` is low in the following cycle.
- R3: A read holds chip enable and output enable low for max(access, cycle, output-enable, strobe access) cycles, which is 4 at the defaults. `rd_valid` pulses for one cycle, 5 cycles after acceptance at the defaults. Strobe bit 0 (lower, bits 7:0) and bit 1 (upper, bits 15:8) are low exactly where the mask bit is 1. `rd_data` carries zeros in the lanes that are not selected.
- R4: During a write, write enable is low only while chip enable is low and at least one lane strobe is low. It stays low for at least ceil(60/20)=3 cycles. Data is driven and stays constant throughout, and only the lanes whose mask bit is set change in memory.
- R5: Before write enable falls, the controller holds chip enable low with output enable high for at least ceil(25/20)=2 cycles. `mem_dq_oe` is never high while output enable is low.
- R6: In the cycle where write enable rises, data is still driven and chip enable is still low. In the following cycle the bus is released.
- R7: A write with mask 2'b00 never pulls write enable or chip enable low. It reports `done` one cycle after acceptance and leaves the memory unchanged.
- R8: Chip enable goes high for at least one cycle between transactions, so each transaction that is not skipped produces exactly one falling edge of chip enable.
- R9: `done` is a one-cycle pulse. At the defaults it comes 7 cycles after a write is accepted, with chip enable already high.
- R10: The memory address stays stable for the whole time chip enable is low, including the address 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane mask, bit 0 lower, bit 1 upper |
| ready | output | 1 | Controller idle, request may be taken |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | One-cycle read result strobe |
| done | output | 1 | One-cycle write completion strobe |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_be_n | output | 2 | Byte lane strobes, active low, bit 0 lower, bit 1 upper |
| mem_dq_out | output | 16 | Value to drive on the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Value seen on the data bus |

## Verification
The hardest case to reach from the ports is a partial-lane write that lands on a word already holding data in the other lane. Only a later full read shows whether the untouched byte survived. The bench first writes a full word, then writes only the lower lane and then only the upper lane of the same address, and after each step it reads the whole word back. The bench's memory model puts inverted garbage on the lanes that are not selected, so any lane the controller fails to mask on a read appears in `rd_data`. A zero-mask write is placed between two known reads to show that it left no trace.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_PULSE,
    ST_HOLD,
    ST_END
  } ctrl_state_e;

  // Strobes from control to datapath, decoded from the current state.
  typedef struct packed {
    logic accept;   // load request fields
    logic chip;     // chip select active
    logic outEn;    // memory may drive bus
    logic wrEn;     // write pulse active
    logic drive;    // controller drives bus
    logic capture;  // last access cycle of a read
    logic finish;   // write completion
  } strobe_t;

  function automatic int cycFor(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int RD_CYC    = 4,
  parameter int TURN_CYC  = 2,
  parameter int PULSE_CYC = 3,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             ready,
  output strobe_t          strb
);

  ctrl_state_e state, nextState;
  logic [CNT_W-1:0] cnt, cntLoad;
  logic             accept, cntZero;

  assign ready   = (state == ST_IDLE);
  assign accept  = req && ready;
  assign cntZero = (cnt == '0);

  always_comb begin
    nextState = state;
    cntLoad   = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (!reqWrite) begin
          nextState = ST_READ;
          cntLoad   = CNT_W'(RD_CYC - 1);
        end else if (reqMask == '0) begin
          nextState = ST_END;
        end else begin
          nextState = ST_TURN;
          cntLoad   = CNT_W'(TURN_CYC - 1);
        end
      end
      ST_READ:  if (cntZero) nextState = ST_IDLE;
      ST_TURN:  if (cntZero) begin
        nextState = ST_PULSE;
        cntLoad   = CNT_W'(PULSE_CYC - 1);
      end
      ST_PULSE: if (cntZero) nextState = ST_HOLD;
      ST_HOLD:  nextState = ST_END;
      ST_END:   nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= cntLoad;
      else if (!cntZero)      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.accept  = accept;
    strb.chip    = (state == ST_READ) || (state == ST_TURN) ||
                   (state == ST_PULSE) || (state == ST_HOLD);
    strb.outEn   = (state == ST_READ);
    strb.wrEn    = (state == ST_PULSE);
    strb.drive   = (state == ST_PULSE) || (state == ST_HOLD);
    strb.capture = (state == ST_READ) && cntZero;
    strb.finish  = (state == ST_END);
  end

  // R2: a taken request leaves idle at once
  p_accept_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

  // R7: a zero-mask write skips straight to completion
  p_zero_mask_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && reqWrite && reqMask == '0) |=> (state == ST_END));

endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              done
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic ceNQ, oeNQ, weNQ, dqOeQ, capQ, doneQ, rdValidQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strb.accept) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      maskQ <= reqMask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceNQ     <= 1'b1;
      oeNQ     <= 1'b1;
      weNQ     <= 1'b1;
      dqOeQ    <= 1'b0;
      capQ     <= 1'b0;
      doneQ    <= 1'b0;
      rdValidQ <= 1'b0;
    end else begin
      ceNQ     <= !strb.chip;
      oeNQ     <= !strb.outEn;
      weNQ     <= !strb.wrEn;
      dqOeQ    <= strb.drive;
      capQ     <= strb.capture;
      doneQ    <= strb.finish;
      rdValidQ <= capQ;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       beNQ;
    logic [7:0] rdLaneQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        beNQ    <= 1'b1;
        rdLaneQ <= '0;
      end else begin
        beNQ <= !(strb.chip && maskQ[g]);
        if (capQ) rdLaneQ <= maskQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
      end
    end
    assign memBeN[g]         = beNQ;
    assign rdData[g*8 +: 8]  = rdLaneQ;
  end

  assign memAddr  = addrQ;
  assign memCeN   = ceNQ;
  assign memOeN   = oeNQ;
  assign memWeN   = weNQ;
  assign memDqOut = dataQ;
  assign memDqOe  = dqOeQ;
  assign rdValid  = rdValidQ;
  assign done     = doneQ;

  // R5: never drive while the memory may drive
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dqOeQ |-> oeNQ);

  // R5: turnaround cycle precedes the write pulse
  p_oe_before_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(weNQ) |-> ($past(oeNQ) && !$past(ceNQ)));

  // R4: write pulse only inside a selected, driven window
  p_we_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !weNQ |-> (!ceNQ && (memBeN != '1) && dqOeQ));

  // R6: data held through the rising write edge
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(weNQ) |-> (dqOeQ && !ceNQ));

  // R10: address frozen while selected
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceNQ && $past(!ceNQ)) |-> $stable(addrQ));

  // R3: read strobe lasts one cycle
  p_rdvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdValidQ |=> !rdValidQ);

  // R9: completion strobe lasts one cycle, memory deselected
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |-> (ceNQ && !dqOeQ) ##1 !doneQ);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int ADDR_W   = 17,
  parameter int LANES    = 2,
  parameter int T_AA_NS  = 70,
  parameter int T_RC_NS  = 70,
  parameter int T_DOE_NS = 35,
  parameter int T_BA_NS  = 35,
  parameter int T_WC_NS  = 70,
  parameter int T_PWE_NS = 60,
  parameter int T_AW_NS  = 65,
  parameter int T_SD_NS  = 30,
  parameter int T_HZ_NS  = 25,
  localparam int DATA_W  = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = imax(imax(cycFor(T_AA_NS, CLK_NS), cycFor(T_RC_NS, CLK_NS)),
                               imax(cycFor(T_DOE_NS, CLK_NS), cycFor(T_BA_NS, CLK_NS)));
  localparam int TURN_CYC  = cycFor(T_HZ_NS, CLK_NS);
  localparam int PULSE_CYC = imax(imax(cycFor(T_PWE_NS, CLK_NS), cycFor(T_SD_NS, CLK_NS)),
                                  imax(cycFor(T_AW_NS, CLK_NS) - TURN_CYC,
                                       cycFor(T_WC_NS, CLK_NS) - TURN_CYC - 1));
  localparam int MAX_CYC = imax(RD_CYC, imax(TURN_CYC, PULSE_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  strobe_t strb;

  sramc_ctrl #(
    .LANES(LANES), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC),
    .PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .reqWrite (req_write),
    .reqMask  (req_mask),
    .ready    (ready),
    .strb     (strb)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .reqAddr  (req_addr),
    .reqData  (req_wdata),
    .reqMask  (req_mask),
    .memDqIn  (mem_dq_in),
    .memAddr  (mem_addr),
    .memCeN   (mem_ce_n),
    .memOeN   (mem_oe_n),
    .memWeN   (mem_we_n),
    .memBeN   (mem_be_n),
    .memDqOut (mem_dq_out),
    .memDqOe  (mem_dq_oe),
    .rdData   (rd_data),
    .rdValid  (rd_valid),
    .done     (done)
  );

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int RD_LAT   = 5;  // R3
  localparam int WR_LAT   = 7;  // R9
  localparam int MIN_WE   = 3;  // R4
  localparam int MIN_TURN = 2;  // R5

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic ready, rd_valid, done;
  logic [15:0] rd_data;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = '0;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model and pin monitor
  logic [15:0] memModel [int];
  bit          prevActive = 0, prevCe = 1;
  int          weLow = 0, turnCnt = 0, ceFalls = 0, commits = 0;
  logic [16:0] lastAddr, prevAddr;
  logic [15:0] lastData;
  logic [1:0]  lastBe;

  always @(negedge clk) begin
    bit active;
    logic [15:0] cur;
    if (rst_n) begin
      active = !mem_ce_n && !mem_we_n && (mem_be_n != 2'b11);
      if (mem_dq_oe && !mem_oe_n)
        check(0, "R5 contention", {31'd0, mem_oe_n}, 32'd1);
      if (!mem_ce_n && !prevCe && mem_addr != prevAddr)
        check(0, "R10 address moved", {15'd0, mem_addr}, {15'd0, prevAddr});
      if (!mem_ce_n && prevCe) ceFalls++;
      if (mem_ce_n) turnCnt = 0;
      else if (mem_oe_n && mem_we_n) turnCnt++;
      if (active) begin
        if (!prevActive) begin
          check(turnCnt >= MIN_TURN, "R5 turnaround", turnCnt, MIN_TURN);
          weLow = 0;
        end else if (mem_dq_out != lastData) begin
          check(0, "R4 data moved", {16'd0, mem_dq_out}, {16'd0, lastData});
        end
        if (!mem_dq_oe) check(0, "R4 not driven", 0, 1);
        weLow++;
        lastAddr = mem_addr; lastData = mem_dq_out; lastBe = mem_be_n;
      end else if (prevActive) begin
        check(mem_dq_oe && !mem_ce_n, "R6 hold", {31'd0, mem_dq_oe}, 1);
        check(weLow >= MIN_WE, "R4 pulse width", weLow, MIN_WE);
        cur = memModel.exists(int'(lastAddr)) ? memModel[int'(lastAddr)] : 16'h0;
        if (!lastBe[0]) cur[7:0]  = lastData[7:0];
        if (!lastBe[1]) cur[15:8] = lastData[15:8];
        memModel[int'(lastAddr)] = cur;
        commits++;
      end
      prevActive = active;
      prevCe = mem_ce_n;
      prevAddr = mem_addr;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        cur = memModel.exists(int'(mem_addr)) ? memModel[int'(mem_addr)] : 16'h0;
        mem_dq_in[7:0]  = mem_be_n[0] ? ~cur[7:0]  : cur[7:0];
        mem_dq_in[15:8] = mem_be_n[1] ? ~cur[15:8] : cur[15:8];
      end else begin
        mem_dq_in = 16'hA5C3;
      end
    end
  end

  // One transaction; n = cycles from acceptance to the response strobe
  task automatic txn(input bit wr, input logic [16:0] a, input logic [15:0] d,
                     input logic [1:0] m, output logic [15:0] rdat, output int n);
    @(negedge clk);
    req = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 0;
    check(!ready, "R2 busy after accept", {31'd0, ready}, 0);
    n = 0;
    rdat = '0;
    while (!(wr ? done : rd_valid) && n < 50) begin
      @(negedge clk);
      n++;
    end
    rdat = rd_data;
    @(negedge clk);
    check(!(wr ? done : rd_valid), "R3/R9 strobe one cycle", 1, 0);
  endtask

  task automatic t_reset();
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1 pins idle", {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 32'h1f);
    check(ready && !rd_valid && !done, "R1 status", {29'd0, ready, rd_valid, done}, 32'h4);
  endtask

  task automatic t_full_word();
    logic [15:0] r; int n;
    txn(1, 17'h00010, 16'h1234, 2'b11, r, n);
    check(n == WR_LAT, "R9 write latency", n, WR_LAT);
    txn(0, 17'h00010, 16'h0, 2'b11, r, n);
    check(n == RD_LAT, "R3 read latency", n, RD_LAT);
    check(r == 16'h1234, "R3 full read", r, 16'h1234);
  endtask

  task automatic t_lanes();
    logic [15:0] r; int n;
    txn(1, 17'h00010, 16'hAB55, 2'b01, r, n);
    txn(0, 17'h00010, 16'h0, 2'b11, r, n);
    check(r == 16'h1255, "R4 lower lane only", r, 16'h1255);
    txn(1, 17'h00010, 16'h77EE, 2'b10, r, n);
    txn(0, 17'h00010, 16'h0, 2'b11, r, n);
    check(r == 16'h7755, "R4 upper lane only", r, 16'h7755);
    txn(0, 17'h00010, 16'h0, 2'b01, r, n);
    check(r == 16'h0055, "R3 lower lane read", r, 16'h0055);
    txn(0, 17'h00010, 16'h0, 2'b10, r, n);
    check(r == 16'h7700, "R3 upper lane read", r, 16'h7700);
  endtask

  task automatic t_zero_mask();
    logic [15:0] r; int n, c0, f0;
    c0 = commits; f0 = ceFalls;
    txn(1, 17'h00010, 16'hFFFF, 2'b00, r, n);
    check(n == 1, "R7 skip latency", n, 1);
    check(commits == c0 && ceFalls == f0, "R7 no strobe", commits - c0 + ceFalls - f0, 0);
    txn(0, 17'h00010, 16'h0, 2'b11, r, n);
    check(r == 16'h7755, "R7 memory unchanged", r, 16'h7755);
  endtask

  task automatic t_top_address();
    logic [15:0] r; int n;
    txn(1, 17'h1FFFF, 16'hC0DE, 2'b11, r, n);
    txn(0, 17'h1FFFF, 16'h0, 2'b11, r, n);
    check(r == 16'hC0DE, "R10 top address", r, 16'hC0DE);
  endtask

  task automatic t_back_to_back();
    logic [15:0] r; int n, f0;
    f0 = ceFalls;
    @(negedge clk);
    req = 1; req_write = 1; req_addr = 17'h00200; req_wdata = 16'h5A5A; req_mask = 2'b11;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req_write = 0;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 0;
    n = 0;
    while (!rd_valid && n < 50) begin @(negedge clk); n++; end
    check(rd_data == 16'h5A5A, "R8 back-to-back read", rd_data, 16'h5A5A);
    check(ceFalls - f0 == 2, "R8 deselect between", ceFalls - f0, 2);
    r = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_lanes();
    t_zero_mask();
    t_top_address();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule